// File: doc/BRIEF.md
# Bidirectional Pin Boundary-Scan Cell

This block is the test-access cell that sits between the port logic of one bidirectional I/O pin and its pad. Three per-pin signals pass through it: the direction (output control), the output value and the pad input. It carries them over a serial path only two flops long. Stage 0 holds the direction bit. Stage 1 is shared: it captures the pad input and later supplies the output value to the update latch.

A test controller selects the cell with one of two mode flags. One is the external-test mode, in which the update latches drive the pad. The other is the sample/preload mode, in which the latches are loaded but the pad keeps following the port logic. The controller then pulses capture, shift and update. All stage and latch activity is synchronous to the scan clock. The scan path has no valid/ready handshake, because shifting is paced by the controller every cycle and there is no back-pressure. All pins are plain control and data.

When neither mode is active, the cell is transparent to normal port operation. Under either mode, the pin's pull-up is forced off.

Top module: `bidir_bscan_cell`

## Requirements
- R1: While rst_n is low, both shift stages and both update latches are 0, so scan_out reads 0.
- R2: When capture is high in a scan mode, the next edge loads stage 0 with port_dir and stage 1 with pad_in. scan_out is stage 1.
- R3: When shift is high in a scan mode, each edge moves scan_in into stage 0 and stage 0 into stage 1. A bit on scan_in therefore appears on scan_out two edges later.
- R4: When update is high in a scan mode, the next edge copies stage 0 into the control latch and stage 1 into the data latch.
- R5: If several operation flags are high at once, capture wins over shift and shift wins over update. Only the winning operation acts.
- R6: When neither mode_extest nor mode_sample is high, capture, shift and update are ignored, and the stages and latches keep their values.
- R7: While mode_extest is high, pad_oe equals the control latch and pad_out equals the data latch.
- R8: While mode_extest is low, pad_oe equals port_dir and pad_out equals port_out. This holds under sample/preload as well.
- R9: pad_pullup is 0 whenever mode_extest or mode_sample is high. Otherwise it equals port_pullup.
- R10: pin_in follows pad_in combinationally in every mode, with no register or synchronizer.
- R11: When both mode flags are high, the cell behaves as in external-test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_dir | input | 1 | Direction from port logic (1 = drive) |
| port_out | input | 1 | Output value from port data register |
| port_pullup | input | 1 | Pull-up request from port logic |
| pin_in | output | 1 | Pad input returned to port logic, unsynchronized |
| pad_in | input | 1 | Value read at the pad |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad output enable |
| pad_pullup | output | 1 | Pad pull-up enable |
| scan_in | input | 1 | Serial data into stage 0 |
| scan_out | output | 1 | Serial data out of stage 1 |
| capture | input | 1 | Capture operation flag |
| shift | input | 1 | Shift operation flag |
| update | input | 1 | Update operation flag |
| mode_extest | input | 1 | External-test mode: latches drive the pad |
| mode_sample | input | 1 | Sample/preload mode: latches load, the pad stays with the port |

## Verification
The bench targets the shared stage 1. A cell that captured the output value instead of pad_in would return the wrong bit on scan_out right after capture. The bench also drives flags together. A design with the wrong priority would shift or update in a cycle where capture should win, and its stages would drift from the model.

Pulses outside the scan modes would corrupt scan_out if they were not ignored. Under sample/preload, a design that handed the pad to the latches would show pad_oe/pad_out differing from port_dir/port_out. Random direction, pull-up and pad values check the forced pull-up and the unregistered pin_in in every mode.

// File: rtl/bscan_cell_pkg.sv
package bscan_cell_pkg;
  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_CAPTURE = 2'd1,
    OP_SHIFT   = 2'd2,
    OP_UPDATE  = 2'd3
  } bsc_op_t;

  typedef struct packed {
    logic ctrl;
    logic data;
  } bsc_pair_t;
endpackage

// File: rtl/bsc_op_decode.sv
module bsc_op_decode
  import bscan_cell_pkg::*;
(
  input  logic    capture,
  input  logic    shift,
  input  logic    update,
  input  logic    mode_extest,
  input  logic    mode_sample,
  output bsc_op_t op,
  output logic    scan_sel,
  output logic    drive_sel
);
  always_comb begin
    scan_sel  = mode_extest | mode_sample;
    drive_sel = mode_extest;
    op        = OP_IDLE;
    if (scan_sel) begin
      if (capture)     op = OP_CAPTURE;
      else if (shift)  op = OP_SHIFT;
      else if (update) op = OP_UPDATE;
    end
  end
endmodule

// File: rtl/bsc_shift_stages.sv
module bsc_shift_stages
  import bscan_cell_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  bsc_op_t   op,
  input  logic      cap_ctrl,
  input  logic      cap_pad,
  input  logic      scan_in,
  output bsc_pair_t stages
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stages.ctrl <= RST_VAL;
      stages.data <= RST_VAL;
    end else begin
      case (op)
        OP_CAPTURE: begin
          stages.ctrl <= cap_ctrl;
          stages.data <= cap_pad;
        end
        OP_SHIFT: begin
          stages.ctrl <= scan_in;
          stages.data <= stages.ctrl;
        end
        default: ;
      endcase
    end
  end

  // R2: capture loads direction and pad value
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CAPTURE |=> stages.ctrl == $past(cap_ctrl) && stages.data == $past(cap_pad));
  // R3: shift moves bits one stage per edge
  p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_SHIFT |=> stages.ctrl == $past(scan_in) && stages.data == $past(stages.ctrl));
  // R6: idle keeps the stages
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE || op == OP_UPDATE) |=> $stable(stages));
endmodule

// File: rtl/bsc_update_latch.sv
module bsc_update_latch
  import bscan_cell_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  bsc_op_t   op,
  input  bsc_pair_t stages,
  output bsc_pair_t latched
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              latched <= '{ctrl: RST_VAL, data: RST_VAL};
    else if (op == OP_UPDATE) latched <= stages;
  end

  // R4: update copies both stages
  p_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_UPDATE |=> latched == $past(stages));
  // R6: latches hold without update
  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op != OP_UPDATE |=> $stable(latched));
endmodule

// File: rtl/bsc_pad_mux.sv
module bsc_pad_mux
  import bscan_cell_pkg::*;
(
  input  logic      scan_sel,
  input  logic      drive_sel,
  input  bsc_pair_t latched,
  input  logic      port_dir,
  input  logic      port_out,
  input  logic      port_pullup,
  input  logic      pad_in,
  output logic      pad_oe,
  output logic      pad_out,
  output logic      pad_pullup,
  output logic      pin_in
);
  always_comb begin
    pad_oe     = drive_sel ? latched.ctrl : port_dir;
    pad_out    = drive_sel ? latched.data : port_out;
    pad_pullup = port_pullup & ~scan_sel;
    pin_in     = pad_in;
  end
endmodule

// File: rtl/bidir_bscan_cell.sv
module bidir_bscan_cell
  import bscan_cell_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic port_dir,
  input  logic port_out,
  input  logic port_pullup,
  output logic pin_in,
  input  logic pad_in,
  output logic pad_out,
  output logic pad_oe,
  output logic pad_pullup,
  input  logic scan_in,
  output logic scan_out,
  input  logic capture,
  input  logic shift,
  input  logic update,
  input  logic mode_extest,
  input  logic mode_sample
);
  bsc_op_t   op;
  logic      scan_sel, drive_sel;
  bsc_pair_t stages, latched;

  bsc_op_decode u_dec (
    .capture(capture), .shift(shift), .update(update),
    .mode_extest(mode_extest), .mode_sample(mode_sample),
    .op(op), .scan_sel(scan_sel), .drive_sel(drive_sel)
  );

  bsc_shift_stages #(.RST_VAL(RST_VAL)) u_stg (
    .clk(clk), .rst_n(rst_n), .op(op), .cap_ctrl(port_dir),
    .cap_pad(pad_in), .scan_in(scan_in), .stages(stages)
  );

  bsc_update_latch #(.RST_VAL(RST_VAL)) u_lat (
    .clk(clk), .rst_n(rst_n), .op(op), .stages(stages), .latched(latched)
  );

  bsc_pad_mux u_mux (
    .scan_sel(scan_sel), .drive_sel(drive_sel), .latched(latched),
    .port_dir(port_dir), .port_out(port_out), .port_pullup(port_pullup),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pullup(pad_pullup), .pin_in(pin_in)
  );

  assign scan_out = stages.data;

  // R5: capture wins over shift and update
  p_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && (mode_extest || mode_sample)) |=> scan_out == $past(pad_in));
  // R7 / R11: extest hands pad to latches
  p_extest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_extest |-> pad_oe == latched.ctrl && pad_out == latched.data);
  // R8: otherwise pad follows port
  p_transparent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_extest |-> pad_oe == port_dir && pad_out == port_out);
  // R9: pull-up off in scan modes
  p_pullup_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_extest || mode_sample) |-> !pad_pullup);
  // R10: pin_in tracks pad_in
  p_pin_direct_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pin_in == pad_in);
endmodule

// File: tb/tb_bidir_bscan_cell.sv
module tb_bidir_bscan_cell;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic port_dir = 0, port_out = 0, port_pullup = 0, pad_in = 0, scan_in = 0;
  logic capture = 0, shift = 0, update = 0, mode_extest = 0, mode_sample = 0;
  logic pin_in, pad_out, pad_oe, pad_pullup, scan_out;
  int n_cmp = 0, n_bad = 0;
  logic m_s0 = 0, m_s1 = 0, m_lc = 0, m_ld = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bidir_bscan_cell dut (.*);

  function automatic logic exp_oe();
    return mode_extest ? m_lc : port_dir;
  endfunction
  function automatic logic exp_out();
    return mode_extest ? m_ld : port_out;
  endfunction
  function automatic logic exp_pu();
    return port_pullup & ~(mode_extest | mode_sample);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R3 scan_out"}, scan_out, m_s1);
    chk({tag, " R7/R8/R11 pad_oe"}, pad_oe, exp_oe());
    chk({tag, " R7/R8/R11 pad_out"}, pad_out, exp_out());
    chk({tag, " R9 pad_pullup"}, pad_pullup, exp_pu());
    chk({tag, " R10 pin_in"}, pin_in, pad_in);
  endtask

  // model one edge from inputs held at that edge (R2-R6)
  task automatic step(input string tag);
    logic s0, s1;
    @(posedge clk);
    s0 = m_s0; s1 = m_s1;
    if (mode_extest || mode_sample) begin
      if (capture) begin m_s0 = port_dir; m_s1 = pad_in; end
      else if (shift) begin m_s0 = scan_in; m_s1 = s0; end
      else if (update) begin m_lc = s0; m_ld = s1; end
    end
    #1 check_all(tag);
    @(negedge clk);
  endtask

  task automatic drive(input logic c, s, u, ex, sa, si);
    capture = c; shift = s; update = u; mode_extest = ex; mode_sample = sa; scan_in = si;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    port_pullup = 1; pad_in = 1; port_dir = 1;
    drive(1, 1, 1, 0, 1, 1);
    repeat (2) @(negedge clk);
    chk("R1 reset scan_out", scan_out, 1'b0);
    chk("R9 pullup forced in sample during reset", pad_pullup, 1'b0);
    chk("R10 pin_in during reset", pin_in, 1'b1);
    rst_n = 1;
    drive(0, 0, 0, 0, 0, 0);
    @(negedge clk);

    // R2: capture direction=1, pad=0 in sample mode
    port_dir = 1; pad_in = 0; drive(1, 0, 0, 0, 1, 0); step("R2 cap");
    chk("R2 captured pad", scan_out, 1'b0);
    // R3: shift out stage0 (direction) then scan_in bits
    drive(0, 1, 0, 0, 1, 1); step("R3 sh1");
    chk("R3 stage0 to out", scan_out, 1'b1);
    drive(0, 1, 0, 0, 1, 0); step("R3 sh2");
    chk("R3 scan_in after two edges", scan_out, 1'b1);
    // R4 + R8: update under sample, pad stays with port
    port_dir = 0; port_out = 1; drive(0, 0, 1, 0, 1, 0); step("R4 upd");
    chk("R8 sample keeps port oe", pad_oe, 1'b0);
    // R7: extest now shows latches (ctrl=0,data=1)
    drive(0, 0, 0, 1, 0, 0); port_out = 0; step("R7 ext");
    chk("R7 latched data drives pad", pad_out, 1'b1);
    // R5: capture+shift+update together -> capture only
    pad_in = 1; port_dir = 0; drive(1, 1, 1, 1, 0, 1); step("R5 prio");
    chk("R5 capture wins", scan_out, 1'b1);
    // R6: modes off, pulses ignored
    pad_in = 0; drive(1, 0, 0, 0, 0, 0); step("R6 cap");
    drive(0, 1, 0, 0, 0, 0); step("R6 sh");
    drive(0, 0, 1, 0, 0, 0); step("R6 upd");
    chk("R6 stage1 held", scan_out, 1'b1);
    // R11: both modes -> extest behaviour
    port_out = 0; drive(0, 0, 0, 1, 1, 0); step("R11 both");
    chk("R11 pad_out from latch", pad_out, m_ld);

    for (int i = 0; i < 400; i++) begin
      int k;
      port_dir = $urandom_range(0, 1); port_out = $urandom_range(0, 1);
      port_pullup = $urandom_range(0, 1); pad_in = $urandom_range(0, 1);
      k = $urandom_range(0, 7);
      drive(k == 0 || k == 5, k == 1 || k == 5 || k == 6, k == 2 || k == 6,
            $urandom_range(0, 2) == 0, $urandom_range(0, 1), $urandom_range(0, 1));
      #1 check_all("rand comb");
      step("rand");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule